// File: doc/BRIEF.md
# Reset Source Capture Controller

This block records which event caused the most recent system reset and lets software request a reset of its own. Four causes are recognised: power-on, an external reset request, a watchdog timeout and a software request. Each cause has its own sticky status bit. The status register sits in the power-on domain only, so a reset service routine can read it after any other kind of reset and find out why the chip restarted.

Software talks to the block through a small single-cycle register port. Address 0 is an 8-bit status register that can be read and written. Address 1 is an 8-bit clear register that can only be written. The block drives a stretched system reset to the rest of the chip. This output also stands in for the pin-default reset. A second output resets the watchdog timer, and only power-on asserts it.

Top module: `rcc_top`

## Requirements
- R1: While por_n is low, the status register holds 0x01: only bit 0 (power-on) is set and every other cause bit is cleared. Status bits 7 to 4 always read as 0.
- R2: A high wdt_timeout sampled on a clock edge sets status bit 1 after that edge. The other bits do not change.
- R3: A high ext_rst_req sampled on a clock edge sets status bit 3 after that edge.
- R4: A write to address 0 with data bit 2 = 1 sets status bit 2 and starts a software reset. Written zeros, and written ones in bits 0, 1 and 3, have no effect on the status.
- R5: A write to address 1 clears every status bit whose data bit is 1. Data bits of 0 leave their status bits alone.
- R6: When status bit 2 is set, a write to address 1 whose data bit 2 is 0 starts a new software reset. When bit 2 is already 0, a write to address 1 starts no reset.
- R7: sys_rst_o goes high after the first clock edge that samples a reset request (external, watchdog or software). It stays high until 4 edges have passed since the last sampled request. It is also high during power-on and for 4 edges after it.
- R8: System resets from the external, watchdog and software causes leave the status register unchanged.
- R9: wdt_rst_o is high while por_n is low and for 4 edges after por_n is released. No other cause ever asserts it.
- R10: A read of address 1 returns 0x00. Read data is valid in the same cycle that the address is presented, with no wait states.
- R11: If a hardware cause and a clear write for the same status bit come in the same cycle, the bit ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| ext_rst_req | input | 1 | External reset request, level, synchronous |
| wdt_timeout | input | 1 | Watchdog timeout request |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 1 | Register select: 0 status, 1 clear |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from bus_addr |
| sys_rst_o | output | 1 | Stretched system and pin-default reset, active high |
| wdt_rst_o | output | 1 | Watchdog timer reset, active high |

## Verification
Read data is combinational, so the bench samples it 1 ns after it changes the address, with no clock edge in between. Status changes and the first cycle of sys_rst_o are due one edge after a stimulus is sampled. The bench drives inputs on the falling edge and observes on the next falling edge. The tail of sys_rst_o is checked at the third and fourth edges after the last request. It must still be high at the third and low at the fourth. A scoreboard item is queued only at those sample points.

// File: rtl/rcc_pkg.sv
package rcc_pkg;
    localparam int unsigned REG_W   = 8;
    localparam int unsigned CAUSE_W = 4;
    localparam int unsigned BIT_POR = 0;
    localparam int unsigned BIT_WDT = 1;
    localparam int unsigned BIT_SW  = 2;
    localparam int unsigned BIT_EXT = 3;

    typedef enum logic {
        ADDR_STAT = 1'b0,
        ADDR_CLR  = 1'b1
    } rcc_addr_e;

    typedef struct packed {
        logic [CAUSE_W-1:0] cause;
    } rcc_stat_t;
endpackage

// File: rtl/rcc_regif.sv
module rcc_regif
    import rcc_pkg::*;
(
    input  logic               bus_wr,
    input  logic               bus_addr,
    input  logic [REG_W-1:0]   bus_wdata,
    input  logic [CAUSE_W-1:0] cause_q,
    output logic               sw_req,
    output logic               clr_wr,
    output logic [CAUSE_W-1:0] clr_mask,
    output logic [REG_W-1:0]   bus_rdata
);
    localparam int unsigned PAD_W = REG_W - CAUSE_W;

    logic unused_hi;
    assign unused_hi = ^bus_wdata[REG_W-1:CAUSE_W];

    always_comb begin
        sw_req    = 1'b0;
        clr_wr    = 1'b0;
        clr_mask  = '0;
        bus_rdata = '0;
        if (bus_wr) begin
            if (rcc_addr_e'(bus_addr) == ADDR_STAT) begin
                sw_req = bus_wdata[BIT_SW];
            end else begin
                clr_wr   = 1'b1;
                clr_mask = bus_wdata[CAUSE_W-1:0];
            end
        end
        if (rcc_addr_e'(bus_addr) == ADDR_STAT) begin
            bus_rdata = {{PAD_W{1'b0}}, cause_q};
        end
    end
endmodule

// File: rtl/rcc_status.sv
module rcc_status
    import rcc_pkg::*;
(
    input  logic               clk,
    input  logic               por_n,
    input  logic [CAUSE_W-1:0] hw_set,
    input  logic               sw_req,
    input  logic               clr_wr,
    input  logic [CAUSE_W-1:0] clr_mask,
    output logic [CAUSE_W-1:0] cause_q,
    output logic               sw_fire
);
    localparam logic [CAUSE_W-1:0] POR_VAL = CAUSE_W'(1) << BIT_POR;

    rcc_stat_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        sw_fire = 1'b0;
        // clears first, so that a cause arriving in the same cycle wins
        if (clr_wr) begin
            st_d.cause = st_d.cause & ~clr_mask;
            if (st_q.cause[BIT_SW] && !clr_mask[BIT_SW]) begin
                sw_fire = 1'b1;
            end
        end
        if (sw_req) begin
            st_d.cause[BIT_SW] = 1'b1;
            sw_fire            = 1'b1;
        end
        st_d.cause = st_d.cause | hw_set;
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            st_q.cause <= POR_VAL;
        end else begin
            st_q <= st_d;
        end
    end

    assign cause_q = st_q.cause;
endmodule

// File: rtl/rcc_stretch.sv
module rcc_stretch #(
    parameter int unsigned HOLD_CYC = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req,
    output logic active
);
    localparam int unsigned CNT_W = $clog2(HOLD_CYC + 1);
    localparam logic [CNT_W-1:0] HOLD_V = CNT_W'(HOLD_CYC);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } stretch_t;

    stretch_t sr_d, sr_q;

    always_comb begin
        sr_d = sr_q;
        if (req) begin
            sr_d.cnt = HOLD_V;
        end else if (sr_q.cnt != '0) begin
            sr_d.cnt = sr_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sr_q.cnt <= HOLD_V;
        end else begin
            sr_q <= sr_d;
        end
    end

    assign active = (sr_q.cnt != '0);
endmodule

// File: rtl/rcc_top.sv
module rcc_top
    import rcc_pkg::*;
#(
    parameter int unsigned HOLD_CYC = 4
) (
    input  logic             clk,
    input  logic             por_n,
    input  logic             ext_rst_req,
    input  logic             wdt_timeout,
    input  logic             bus_wr,
    input  logic             bus_addr,
    input  logic [REG_W-1:0] bus_wdata,
    output logic [REG_W-1:0] bus_rdata,
    output logic             sys_rst_o,
    output logic             wdt_rst_o
);
    logic [CAUSE_W-1:0] cause_q;
    logic [CAUSE_W-1:0] clr_mask;
    logic [CAUSE_W-1:0] hw_set;
    logic               sw_req;
    logic               clr_wr;
    logic               sw_fire;
    logic               any_req;

    always_comb begin
        hw_set          = '0;
        hw_set[BIT_WDT] = wdt_timeout;
        hw_set[BIT_EXT] = ext_rst_req;
    end

    rcc_regif u_regif (
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .cause_q   (cause_q),
        .sw_req    (sw_req),
        .clr_wr    (clr_wr),
        .clr_mask  (clr_mask),
        .bus_rdata (bus_rdata)
    );

    rcc_status u_status (
        .clk      (clk),
        .por_n    (por_n),
        .hw_set   (hw_set),
        .sw_req   (sw_req),
        .clr_wr   (clr_wr),
        .clr_mask (clr_mask),
        .cause_q  (cause_q),
        .sw_fire  (sw_fire)
    );

    assign any_req = ext_rst_req | wdt_timeout | sw_fire;

    rcc_stretch #(.HOLD_CYC(HOLD_CYC)) u_sys_str (
        .clk    (clk),
        .rst_n  (por_n),
        .req    (any_req),
        .active (sys_rst_o)
    );

    rcc_stretch #(.HOLD_CYC(HOLD_CYC)) u_wdt_str (
        .clk    (clk),
        .rst_n  (por_n),
        .req    (1'b0),
        .active (wdt_rst_o)
    );
endmodule

// File: rtl/rcc_chk.sv
module rcc_chk
    import rcc_pkg::*;
(
    input logic               clk,
    input logic               por_n,
    input logic               ext_rst_req,
    input logic               wdt_timeout,
    input logic               bus_wr,
    input logic               bus_addr,
    input logic [REG_W-1:0]   bus_wdata,
    input logic [REG_W-1:0]   bus_rdata,
    input logic               sys_rst_o,
    input logic               wdt_rst_o,
    input logic [CAUSE_W-1:0] cause_q
);
    // R1
    upper_zero_chk: assert property (@(posedge clk) disable iff (!por_n)
        bus_rdata[REG_W-1:CAUSE_W] == '0);

    // R2
    wdt_cause_chk: assert property (@(posedge clk) disable iff (!por_n)
        wdt_timeout |=> cause_q[BIT_WDT]);

    // R3
    ext_cause_chk: assert property (@(posedge clk) disable iff (!por_n)
        ext_rst_req |=> cause_q[BIT_EXT]);

    // R5
    clr_por_chk: assert property (@(posedge clk) disable iff (!por_n)
        (bus_wr && bus_addr && bus_wdata[BIT_POR]) |=> !cause_q[BIT_POR]);

    // R6
    sw_refire_chk: assert property (@(posedge clk) disable iff (!por_n)
        (bus_wr && bus_addr && cause_q[BIT_SW] && !bus_wdata[BIT_SW]) |=> sys_rst_o);

    // R7
    sys_rise_chk: assert property (@(posedge clk) disable iff (!por_n)
        (ext_rst_req || wdt_timeout) |=> sys_rst_o);

    // R9
    wdt_quiet_chk: assert property (@(posedge clk) disable iff (!por_n)
        !wdt_rst_o |=> !wdt_rst_o);

    // R10
    clr_read_chk: assert property (@(posedge clk) disable iff (!por_n)
        bus_addr |-> (bus_rdata == '0));
endmodule

bind rcc_top rcc_chk u_chk (
    .clk         (clk),
    .por_n       (por_n),
    .ext_rst_req (ext_rst_req),
    .wdt_timeout (wdt_timeout),
    .bus_wr      (bus_wr),
    .bus_addr    (bus_addr),
    .bus_wdata   (bus_wdata),
    .bus_rdata   (bus_rdata),
    .sys_rst_o   (sys_rst_o),
    .wdt_rst_o   (wdt_rst_o),
    .cause_q     (cause_q)
);

// File: tb/rcc_top_test.sv
module rcc_top_test;
    logic       clk = 1'b0;
    logic       por_n = 1'b0;
    logic       ext_rst_req = 1'b0;
    logic       wdt_timeout = 1'b0;
    logic       bus_wr = 1'b0;
    logic       bus_addr = 1'b0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic       sys_rst_o;
    logic       wdt_rst_o;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    typedef struct {
        string      tag;
        logic [7:0] rd;
        logic       sys;
        logic       wdt;
    } item_t;

    item_t sb_q[$];
    event  sample_ev;

    always #5 clk = ~clk;

    rcc_top uut (
        .clk         (clk),
        .por_n       (por_n),
        .ext_rst_req (ext_rst_req),
        .wdt_timeout (wdt_timeout),
        .bus_wr      (bus_wr),
        .bus_addr    (bus_addr),
        .bus_wdata   (bus_wdata),
        .bus_rdata   (bus_rdata),
        .sys_rst_o   (sys_rst_o),
        .wdt_rst_o   (wdt_rst_o)
    );

    // monitor: pops each expected item and compares with the ports
    initial begin
        forever begin
            @(sample_ev);
            while (sb_q.size() > 0) begin
                item_t it;
                it = sb_q.pop_front();
                checks++;
                if (bus_rdata !== it.rd || sys_rst_o !== it.sys || wdt_rst_o !== it.wdt) begin
                    errors++;
                    $display("FAIL %s: rdata=%h sys=%b wdt=%b expected rdata=%h sys=%b wdt=%b",
                             it.tag, bus_rdata, sys_rst_o, wdt_rst_o, it.rd, it.sys, it.wdt);
                end
            end
        end
    end

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic expect_obs(input string tag, input logic addr, input logic [7:0] rd,
                              input logic sys, input logic wdt);
        item_t it;
        bus_addr = addr;
        #1;
        it.tag = tag; it.rd = rd; it.sys = sys; it.wdt = wdt;
        sb_q.push_back(it);
        ->sample_ev;
        #1;
    endtask

    task automatic wr(input logic addr, input logic [7:0] data);
        bus_wr = 1'b1; bus_addr = addr; bus_wdata = data;
        tick();
        bus_wr = 1'b0; bus_wdata = 8'h00; bus_addr = 1'b0;
    endtask

    task automatic settle();
        repeat (6) tick();
    endtask

    initial begin
        repeat (3) tick();
        expect_obs("R9 R7 during power-on", 1'b0, 8'h01, 1'b1, 1'b1);
        por_n = 1'b1;
        repeat (3) tick();
        expect_obs("R7 R9 third edge after power-on", 1'b0, 8'h01, 1'b1, 1'b1);
        tick();
        expect_obs("R1 R7 R9 fourth edge after power-on", 1'b0, 8'h01, 1'b0, 1'b0);

        // watchdog pulse
        wdt_timeout = 1'b1; tick(); wdt_timeout = 1'b0;
        expect_obs("R2 R7 watchdog sets bit 1", 1'b0, 8'h03, 1'b1, 1'b0);
        repeat (3) tick();
        expect_obs("R7 watchdog tail third edge", 1'b0, 8'h03, 1'b1, 1'b0);
        tick();
        expect_obs("R7 R9 R8 watchdog tail end", 1'b0, 8'h03, 1'b0, 1'b0);

        // clear and ignored writes
        wr(1'b1, 8'h03);
        expect_obs("R5 clear bits 0 and 1", 1'b0, 8'h00, 1'b0, 1'b0);
        wr(1'b0, 8'hFB);
        expect_obs("R4 status write without bit 2 ignored", 1'b0, 8'h00, 1'b0, 1'b0);

        // external level for three cycles
        ext_rst_req = 1'b1; tick();
        expect_obs("R3 R7 external sets bit 3", 1'b0, 8'h08, 1'b1, 1'b0);
        repeat (2) tick(); ext_rst_req = 1'b0;
        repeat (3) tick();
        expect_obs("R7 external tail third edge", 1'b0, 8'h08, 1'b1, 1'b0);
        tick();
        expect_obs("R7 R8 external tail end", 1'b0, 8'h08, 1'b0, 1'b0);

        // software reset
        wr(1'b0, 8'h04);
        expect_obs("R4 software bit set and reset", 1'b0, 8'h0C, 1'b1, 1'b0);
        settle();
        expect_obs("R8 R9 status kept after software reset", 1'b0, 8'h0C, 1'b0, 1'b0);
        wr(1'b0, 8'h00);
        expect_obs("R4 writing zeros does not clear", 1'b0, 8'h0C, 1'b0, 1'b0);
        wr(1'b1, 8'h08);
        expect_obs("R6 R5 clear leaving bit 2 refires", 1'b0, 8'h04, 1'b1, 1'b0);
        settle();
        wr(1'b1, 8'h04);
        expect_obs("R6 clearing bit 2 fires nothing", 1'b0, 8'h00, 1'b0, 1'b0);
        wr(1'b1, 8'h00);
        expect_obs("R6 clear write with bit 2 low is quiet", 1'b0, 8'h00, 1'b0, 1'b0);

        // clear register read
        expect_obs("R10 clear address reads zero", 1'b1, 8'h00, 1'b0, 1'b0);

        // simultaneous cause and clear
        wdt_timeout = 1'b1; wr(1'b1, 8'h02); wdt_timeout = 1'b0;
        expect_obs("R11 cause beats clear", 1'b0, 8'h02, 1'b1, 1'b0);
        settle();
        ext_rst_req = 1'b1; wr(1'b0, 8'h04); ext_rst_req = 1'b0;
        expect_obs("R3 R4 external plus software", 1'b0, 8'h0E, 1'b1, 1'b0);
        settle();

        // second power-on wipes accumulated causes
        por_n = 1'b0; tick();
        expect_obs("R1 R9 power-on wipes causes", 1'b0, 8'h01, 1'b1, 1'b1);
        por_n = 1'b1;
        repeat (4) tick();
        expect_obs("R1 R9 after second power-on", 1'b0, 8'h01, 1'b0, 1'b0);

        tick();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: run did not complete, actual=hung expected=done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule